// File: doc/BRIEF.md
# ADC Control Register and Converter Clock Prescaler

This block sits between a byte-wide CPU register port and an analog-to-digital converter core. It holds two 8-bit control/status registers. It divides the system clock down to a converter clock enable, which is a single-cycle strobe whose spacing is chosen by a 3-bit code. It also decides when a conversion starts, either from a software request bit or from the rising edge of one selected event line.

When the core signals that a conversion has finished and its result has been stored, the block raises an end-of-conversion flag. If the matching enable bit is set, it then raises an interrupt request. The flag clears when the interrupt is acknowledged or when software writes a one to it. A new completion arriving in the same cycle as either clear wins.

A high-speed bit is held in the registers and driven straight to the converter core. It allows the core to run its clock above 200 kHz. The converter itself is outside this block.

Top module: `adc_ctrl_top`

## Requirements
- R1: The converter clock enable is a one-cycle pulse repeating every F system clocks. The divide code in control bits [2:0] selects F as follows: codes 0 and 1 give 2, code 2 gives 4, code 3 gives 8, code 4 gives 16, code 5 gives 32, code 6 gives 64 and code 7 gives 128.
- R2: A write that changes the divide code restarts the count. The first pulse after such a write appears F+1 cycles after the write edge.
- R3: A conversion-done pulse sets the end-of-conversion flag, which reads back as control bit 4 on the cycle after the pulse.
- R4: An interrupt-acknowledge pulse clears the flag.
- R5: Writing control (address 0) with bit 4 at one clears the flag. Writing bit 4 at zero leaves the flag unchanged.
- R6: The interrupt request is high exactly when both the flag and the interrupt enable (control bit 3) are set.
- R7: If a done pulse coincides with an acknowledge or with a write-one-to-clear, the flag ends up set.
- R8: Writing trigger register (address 1) bit 4 at one while idle gives one start pulse two cycles after the write edge. The bit then reads zero. A request written while a conversion is busy waits for the done pulse and launches two cycles after it. Writing the bit at zero before then cancels the request.
- R9: When auto-trigger (control bit 5) is set, a rising edge on the event line picked by trigger bits [3:0] gives a start pulse one cycle after the edge. Edges on other lines, a line held high, and any edge while auto-trigger is clear give no start.
- R10: A trigger edge that arrives while a conversion is busy, meaning after a start and before the done pulse, is dropped and does not start a conversion later.
- R11: All register fields reset to zero. Trigger bit 7 (high speed) reads back as written, drives the high-speed output, and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 control, 1 trigger |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| conv_done_i | input | 1 | Conversion complete, result stored |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| trig_i | input | NUM_TRIG | Auto-trigger event lines |
| conv_clk_en_o | output | 1 | Converter clock enable strobe |
| conv_start_o | output | 1 | Conversion start pulse |
| irq_o | output | 1 | End-of-conversion interrupt request |
| hs_mode_o | output | 1 | High-speed mode to converter core |

## Verification
The bench builds the block with its default parameters: a 3-bit divide code and a 4-bit trigger select over 16 event lines. This lets it sweep all eight divide codes, including the longest 128-cycle period. It also lets it launch conversions from the lowest-numbered middle line and from the highest line, number 15. A scoreboard predicts the cycle of every start pulse, so the busy-drop, pending-request and cancelled-request cases are all judged on exact timing.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int BUS_W = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_TRIG = 1'b1;
  // control register fields
  localparam int CTRL_PSC_LSB = 0;
  localparam int CTRL_IEN     = 3;
  localparam int CTRL_IFLAG   = 4;
  localparam int CTRL_AUTO    = 5;
  // trigger register fields
  localparam int TRIG_SEL_LSB = 0;
  localparam int TRIG_START   = 4;
  localparam int TRIG_HS      = 7;

  // terminal count for a divide code: codes 0 and 1 both divide by 2
  function automatic int unsigned psc_limit(input int unsigned code);
    return (code < 2) ? 1 : ((1 << code) - 1);
  endfunction
endpackage

// File: rtl/adc_ctrl_psc.sv
module adc_ctrl_psc import adc_ctrl_pkg::*; #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             clk_en
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb lim = CNT_W'(psc_limit(int'(sel)));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      clk_en <= 1'b0;
    end else if (cnt_q == lim) begin
      cnt_q  <= '0;
      clk_en <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      clk_en <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_ctrl_irq.sv
module adc_ctrl_irq (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic ack,
  input  logic w1c,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)             flag <= 1'b0;
    else if (done)       flag <= 1'b1;  // completion wins over any clear
    else if (ack || w1c) flag <= 1'b0;
  end
endmodule

// File: rtl/adc_ctrl_launch.sv
module adc_ctrl_launch #(
  parameter int SEL_W = 4,
  localparam int NUM = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   trig,
  input  logic [SEL_W-1:0] trig_sel,
  input  logic             auto_en,
  input  logic             req_wr,
  input  logic             req_wval,
  input  logic             done,
  output logic             start_o,
  output logic             start_req,
  output logic             busy
);
  logic [NUM-1:0] prev_q;
  logic edge_hit, launch;

  always_comb begin
    edge_hit = trig[trig_sel] & ~prev_q[trig_sel];
    launch   = !busy && (start_req || (auto_en && edge_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      start_o   <= 1'b0;
      start_req <= 1'b0;
      busy      <= 1'b0;
    end else begin
      prev_q  <= trig;
      start_o <= launch;
      if (launch)    busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (launch)      start_req <= 1'b0;
      else if (req_wr) start_req <= req_wval;
    end
  end
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top import adc_ctrl_pkg::*; #(
  parameter int PSC_SEL_W  = 3,
  parameter int TRIG_SEL_W = 4,
  localparam int NUM_TRIG  = 1 << TRIG_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               conv_done_i,
  input  logic               irq_ack_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic               conv_clk_en_o,
  output logic               conv_start_o,
  output logic               irq_o,
  output logic               hs_mode_o
);
  logic [PSC_SEL_W-1:0]  psc_sel_q;
  logic [TRIG_SEL_W-1:0] trig_sel_q;
  logic irq_en_q, auto_en_q, hs_q;
  logic irq_flag, start_req, busy;
  logic wr_ctrl, wr_trig, psc_restart, flag_w1c;

  always_comb begin
    wr_ctrl     = bus_we && (bus_addr == ADDR_CTRL);
    wr_trig     = bus_we && (bus_addr == ADDR_TRIG);
    psc_restart = wr_ctrl && (bus_wdata[CTRL_PSC_LSB +: PSC_SEL_W] != psc_sel_q);
    flag_w1c    = wr_ctrl && bus_wdata[CTRL_IFLAG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_sel_q  <= '0;
      irq_en_q   <= 1'b0;
      auto_en_q  <= 1'b0;
      trig_sel_q <= '0;
      hs_q       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        psc_sel_q <= bus_wdata[CTRL_PSC_LSB +: PSC_SEL_W];
        irq_en_q  <= bus_wdata[CTRL_IEN];
        auto_en_q <= bus_wdata[CTRL_AUTO];
      end
      if (wr_trig) begin
        trig_sel_q <= bus_wdata[TRIG_SEL_LSB +: TRIG_SEL_W];
        hs_q       <= bus_wdata[TRIG_HS];
      end
    end
  end

  adc_ctrl_psc #(.SEL_W(PSC_SEL_W)) psc_i (
    .clk(clk), .rst(rst), .sel(psc_sel_q), .restart(psc_restart),
    .clk_en(conv_clk_en_o)
  );

  adc_ctrl_irq irq_i (
    .clk(clk), .rst(rst), .done(conv_done_i), .ack(irq_ack_i),
    .w1c(flag_w1c), .flag(irq_flag)
  );

  adc_ctrl_launch #(.SEL_W(TRIG_SEL_W)) launch_i (
    .clk(clk), .rst(rst), .trig(trig_i), .trig_sel(trig_sel_q),
    .auto_en(auto_en_q), .req_wr(wr_trig), .req_wval(bus_wdata[TRIG_START]),
    .done(conv_done_i), .start_o(conv_start_o), .start_req(start_req),
    .busy(busy)
  );

  assign irq_o     = irq_flag & irq_en_q;
  assign hs_mode_o = hs_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) begin
      bus_rdata[CTRL_PSC_LSB +: PSC_SEL_W] = psc_sel_q;
      bus_rdata[CTRL_IEN]   = irq_en_q;
      bus_rdata[CTRL_IFLAG] = irq_flag;
      bus_rdata[CTRL_AUTO]  = auto_en_q;
    end else begin
      bus_rdata[TRIG_SEL_LSB +: TRIG_SEL_W] = trig_sel_q;
      bus_rdata[TRIG_START] = start_req;
      bus_rdata[TRIG_HS]    = hs_q;
    end
  end
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic ack,
  input logic flag,
  input logic irq_en,
  input logic irq,
  input logic start,
  input logic start_req,
  input logic busy,
  input logic clk_en
);
  AST_CLK_EN_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) clk_en |=> !clk_en); // R1
  AST_DONE_SETS_FLAG:  assert property (@(posedge clk) disable iff (rst) done |=> flag); // R7
  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst) (ack && !done) |=> !flag); // R4
  AST_IRQ_NEEDS_EN:    assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> irq_en); // R6
  AST_START_SINGLE:    assert property (@(posedge clk) disable iff (rst) start |=> !start); // R8
  AST_START_DROPS_REQ: assert property (@(posedge clk) disable iff (rst) start |-> !start_req); // R8
  AST_BUSY_NO_START:   assert property (@(posedge clk) disable iff (rst) busy |=> !start); // R10
endmodule

bind adc_ctrl_top adc_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .done(conv_done_i), .ack(irq_ack_i), .flag(irq_flag),
  .irq_en(irq_en_q), .irq(irq_o), .start(conv_start_o), .start_req(start_req),
  .busy(busy), .clk_en(conv_clk_en_o)
);

// File: tb/adc_ctrl_top_tb_top.sv
module adc_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_TRIG = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_addr = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic conv_done_i = 1'b0, irq_ack_i = 1'b0;
  logic [NUM_TRIG-1:0] trig_i = '0;
  logic conv_clk_en_o, conv_start_o, irq_o, hs_mode_o;

  int cyc = 0, n_cmp = 0, n_bad = 0, mon_exp;
  int exp_q[$];
  logic [7:0] rd;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_ctrl_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done_i(conv_done_i),
    .irq_ack_i(irq_ack_i), .trig_i(trig_i), .conv_clk_en_o(conv_clk_en_o),
    .conv_start_o(conv_start_o), .irq_o(irq_o), .hs_mode_o(hs_mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: every start pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (!rst && conv_start_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8/R9/R10 unexpected start actual=%0d expected=none", cyc);
      end else begin
        mon_exp = exp_q.pop_front();
        if (mon_exp != cyc) begin
          n_bad++;
          $display("FAIL R8/R9 start cycle actual=%0d expected=%0d", cyc, mon_exp);
        end
      end
    end
  end

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done_i = 1'b1;
    @(negedge clk); conv_done_i = 1'b0;
  endtask

  task automatic measure_div(input int code);
    int c0, t1, t2, f;
    f = (code < 2) ? 2 : (1 << code);
    @(negedge clk); c0 = cyc; bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'(code);
    @(negedge clk); bus_we = 1'b0;
    t1 = -1; t2 = -1;
    for (int i = 0; i < 400 && t2 < 0; i++) begin
      if (conv_clk_en_o) begin
        if (t1 < 0) t1 = cyc; else t2 = cyc;
      end
      if (t2 < 0) @(negedge clk);
    end
    chk($sformatf("R2 first pulse code %0d", code), t1, c0 + 1 + f);
    chk($sformatf("R1 period code %0d", code), t2 - t1, f);
  endtask

  // start via request bit, predicting the pulse two cycles after the write edge
  task automatic sw_start();
    @(negedge clk); exp_q.push_back(cyc + 2);
    bus_addr = 1'b1; bus_we = 1'b1; bus_wdata = 8'h10;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic trig_rise(input int line, input bit expect_start);
    @(negedge clk); if (expect_start) exp_q.push_back(cyc + 1);
    trig_i[line] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset values
    bus_read(1'b0, rd); chk("R11 ctrl reset", rd, 0);
    bus_read(1'b1, rd); chk("R11 trig reset", rd, 0);
    chk("R11 irq reset", irq_o, 0);
    chk("R11 hs reset", hs_mode_o, 0);

    // R1 / R2 all divide codes
    for (int c = 1; c < 8; c++) measure_div(c);
    measure_div(0);

    // R3 / R6 flag set, gated interrupt
    pulse_done();
    bus_read(1'b0, rd); chk("R3 flag set", rd[4], 1);
    chk("R6 irq off when disabled", irq_o, 0);
    bus_write(1'b0, 8'h08);
    chk("R6 irq on with enable", irq_o, 1);
    chk("R5 write zero keeps flag", irq_o, 1);
    bus_write(1'b0, 8'h18);
    bus_read(1'b0, rd); chk("R5 w1c clears flag", rd[4], 0);
    chk("R6 irq off after clear", irq_o, 0);
    // R4 acknowledge
    pulse_done();
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
    bus_read(1'b0, rd); chk("R4 ack clears flag", rd[4], 0);
    // R7 priority
    @(negedge clk); conv_done_i = 1'b1; irq_ack_i = 1'b1;
    @(negedge clk); conv_done_i = 1'b0; irq_ack_i = 1'b0;
    bus_read(1'b0, rd); chk("R7 done beats ack", rd[4], 1);
    bus_write(1'b0, 8'h18);
    @(negedge clk); conv_done_i = 1'b1; bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'h18;
    @(negedge clk); conv_done_i = 1'b0; bus_we = 1'b0;
    bus_read(1'b0, rd); chk("R7 done beats w1c", rd[4], 1);
    bus_write(1'b0, 8'h10);

    // R8 software start
    sw_start();
    bus_read(1'b1, rd); chk("R8 request self-clears", rd[4], 0);
    bus_write(1'b1, 8'h10);              // pending while busy
    bus_read(1'b1, rd); chk("R8 request pending while busy", rd[4], 1);
    bus_write(1'b1, 8'h00);              // cancel
    bus_read(1'b1, rd); chk("R8 request cancelled", rd[4], 0);
    pulse_done();
    repeat (4) @(negedge clk);
    chk("R8 cancelled request no start", exp_q.size(), 0);
    sw_start();
    bus_write(1'b1, 8'h10);              // pending again
    @(negedge clk); exp_q.push_back(cyc + 2); conv_done_i = 1'b1;
    @(negedge clk); conv_done_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pending request launched after done", exp_q.size(), 0);
    pulse_done();

    // R9 auto trigger
    bus_write(1'b1, 8'h05);
    bus_write(1'b0, 8'h20);
    trig_rise(3, 0);                     // other line ignored
    trig_rise(5, 1);
    repeat (2) @(negedge clk);
    pulse_done();
    repeat (3) @(negedge clk);           // line 5 held high: no new start
    chk("R9 held line and other line no start", exp_q.size(), 0);
    // R10 edge while busy dropped
    trig_i[5] = 1'b0;
    trig_rise(5, 1);
    @(negedge clk); trig_i[5] = 1'b0;
    trig_rise(5, 0);                     // busy: dropped
    pulse_done();
    repeat (4) @(negedge clk);
    chk("R10 busy edge dropped", exp_q.size(), 0);
    // R9 highest line
    trig_i = '0;
    bus_write(1'b1, 8'h0F);
    trig_rise(15, 1);
    repeat (2) @(negedge clk);
    pulse_done();
    trig_i = '0;
    // R9 auto disabled
    bus_write(1'b0, 8'h00);
    trig_rise(15, 0);
    repeat (4) @(negedge clk);
    chk("R9 auto disabled no start", exp_q.size(), 0);
    trig_i = '0;

    // R11 high-speed bit
    bus_write(1'b1, 8'h80);
    bus_read(1'b1, rd); chk("R11 hs readback", rd, 8'h80);
    chk("R11 hs output", hs_mode_o, 1);
    repeat (4) @(negedge clk);
    chk("R11 hs starts nothing", exp_q.size(), 0);

    done_flag = 1;
    summary();
  end
endmodule